// File: doc/BRIEF.md
# Sticky Event Flag Interrupt Controller

This block gathers per-channel event strobes from an optical transceiver's monitoring logic: receiver loss of signal, transmitter loss of signal, transmitter fault and eight monitor alarm and warning comparisons. Each strobe sets a sticky flag bit that stays set until the host reads the byte that holds it. Every flag has its own volatile mask bit. The block drives a shared active-low interrupt whenever any unmasked flag is set.

A byte-wide register port lets the host read the flag bytes, a status byte and the mask bytes, and write the masks. A read returns the byte one cycle later and clears the flag bits it returned. When a clearing read and an event hit the same flag in the same cycle, the event wins and the flag stays set. After reset a data-not-ready bit stays high for a fixed number of cycles. When it drops, the block latches a ready indication that also raises the interrupt until the host reads the status byte.

Top module: `flag_irq_ctrl`

## Requirements
- R1: A flag sets on the cycle after its event input is high, and it stays set after the event returns low for as long as its byte is not read.
- R2: Address 3 returns receiver loss-of-signal flags for channels 1..4 in bits 0..3 and transmitter loss-of-signal flags for channels 1..4 in bits 4..7. The read clears every flag it returned.
- R3: Address 4 returns transmitter fault flags for channels 1..4 in bits 0..3, with bits 4..7 always 0. Address 5 returns monitor flag i in bit i.
- R4: If an event hits a flag in the same cycle as a clearing read of its byte, the flag is still set afterwards, and the next read of that byte returns it.
- R5: A read of one byte leaves the flags of every other byte unchanged.
- R6: Masks reset to 0. A write to address MASK_BASE+k (default 100+k) sets the mask of flag byte 3+k. For byte 4, only bits 0..3 are stored and the others read 0. A read of a mask address returns the mask and does not change it.
- R7: int_n is low exactly when some flag is set with its mask bit clear, or when the ready indication is pending. Masked flags still latch.
- R8: Status byte (address 2) bit 0 is data-not-ready. It is 1 from reset until INIT_CYCLES clock edges after reset release and 0 after that. Its fall raises the interrupt in the same cycle. A read of address 2 then releases the interrupt.
- R9: Status byte bit 1 reads as 1 when the interrupt is asserted at the time of the read. Bits 7..2 read 0.
- R10: rd_valid is high exactly in the cycle after rd_en. Addresses that map to nothing read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_los_ev | input | 4 | Receiver loss-of-signal events, channels 1..4 |
| tx_los_ev | input | 4 | Transmitter loss-of-signal events, channels 1..4 |
| tx_fault_ev | input | 4 | Transmitter fault events, channels 1..4 |
| mon_ev | input | 8 | Monitor alarm/warning comparison events |
| host_addr | input | ADDR_W | Register address for read or write |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Mask write strobe |
| wr_data | input | 8 | Mask write data |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| int_n | output | 1 | Active-low interrupt |

## Verification
Directed sequences each isolate one behaviour:
- a single pulse followed by idle cycles separates a sticky flag from a level-following one;
- an event on the same cycle as a read of its byte exposes which of the two wins;
- loading two bytes and reading only one shows whether clears leak across bytes;
- setting full masks shows whether a flag still latches while its interrupt is blocked.

After these, thousands of cycles of sparse random events interleave with random reads, mask writes and accesses to unmapped addresses. Each result is compared against a reference model of flags, masks and the ready indication kept in the bench. Stale or lost flags, and wrong interrupt levels after mask changes, show up as mismatches.

// File: rtl/flag_irq_pkg.sv
package flag_irq_pkg;
    localparam int FB          = 3;   // number of flag bytes
    localparam int STATUS_ADDR = 2;
    localparam int FLAG_BASE   = 3;

    typedef logic [FB-1:0][7:0] fbytes_t;

    function automatic logic [7:0] valid_bits(input int idx);
        return (idx == 1) ? 8'h0F : 8'hFF;
    endfunction

    function automatic fbytes_t all_valid();
        fbytes_t v;
        for (int i = 0; i < FB; i++) v[i] = valid_bits(i);
        return v;
    endfunction
endpackage

// File: rtl/flag_init_seq.sv
module flag_init_seq #(
    parameter int INIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic dnr,
    output logic done_pulse
);
    localparam int CW = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          dnr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        done_pulse = 1'b0;
        if (seq_q.dnr) begin
            if (seq_q.cnt == CW'(INIT_CYCLES - 1)) begin
                seq_d.dnr  = 1'b0;
                done_pulse = 1'b1;
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.cnt <= '0;
            seq_q.dnr <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign dnr = seq_q.dnr;
endmodule

// File: rtl/flag_latch.sv
module flag_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic         clr,
    output logic [W-1:0] flags
);
    logic [W-1:0] flags_d, flags_q;

    // a clearing read drops the returned bits; a coincident event re-sets them
    always_comb begin
        flags_d = (clr ? '0 : flags_q) | ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/flag_irq_ctrl.sv
module flag_irq_ctrl
    import flag_irq_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int INIT_CYCLES = 16,
    parameter int MASK_BASE   = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rx_los_ev,
    input  logic [3:0]        tx_los_ev,
    input  logic [3:0]        tx_fault_ev,
    input  logic [7:0]        mon_ev,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              int_n
);
    typedef struct packed {
        fbytes_t    mask;
        logic       rdy;
        logic       rd_valid;
        logic [7:0] rd_data;
    } ctl_t;

    ctl_t    ctl_d, ctl_q;
    fbytes_t ev_byte;
    fbytes_t flag_q;
    fbytes_t mask_q;
    logic [FB-1:0] clr_byte;
    logic    dnr_q;
    logic    rdy_pulse;
    logic    rdy_q;
    logic    irq;

    assign ev_byte[0] = {tx_los_ev, rx_los_ev};
    assign ev_byte[1] = {4'b0000, tx_fault_ev};
    assign ev_byte[2] = mon_ev;

    flag_init_seq #(.INIT_CYCLES(INIT_CYCLES)) u_init (
        .clk        (clk),
        .rst_n      (rst_n),
        .dnr        (dnr_q),
        .done_pulse (rdy_pulse)
    );

    for (genvar g = 0; g < FB; g++) begin : g_bank
        assign clr_byte[g] = rd_en && (host_addr == ADDR_W'(FLAG_BASE + g));
        flag_latch #(.W(8)) u_flags (
            .clk   (clk),
            .rst_n (rst_n),
            .ev    (ev_byte[g]),
            .clr   (clr_byte[g]),
            .flags (flag_q[g])
        );
    end

    assign mask_q = ctl_q.mask;
    assign rdy_q  = ctl_q.rdy;
    assign irq    = (|(flag_q & ~mask_q)) | rdy_q;

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rd_valid = rd_en;
        ctl_d.rd_data  = '0;
        if (rd_en) begin
            if (host_addr == ADDR_W'(STATUS_ADDR)) begin
                ctl_d.rd_data = {6'b0, irq, dnr_q};
                ctl_d.rdy     = 1'b0;
            end
            for (int i = 0; i < FB; i++) begin
                if (host_addr == ADDR_W'(FLAG_BASE + i)) ctl_d.rd_data = flag_q[i];
                if (host_addr == ADDR_W'(MASK_BASE + i)) ctl_d.rd_data = ctl_q.mask[i];
            end
        end
        if (wr_en) begin
            for (int i = 0; i < FB; i++) begin
                if (host_addr == ADDR_W'(MASK_BASE + i))
                    ctl_d.mask[i] = wr_data & valid_bits(i);
            end
        end
        if (rdy_pulse) ctl_d.rdy = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rd_data  = ctl_q.rd_data;
    assign rd_valid = ctl_q.rd_valid;
    assign int_n    = ~irq;
endmodule

// File: rtl/flag_irq_checker.sv
module flag_irq_checker
    import flag_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        rx_los_ev,
    input logic [3:0]        tx_los_ev,
    input logic [ADDR_W-1:0] host_addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic              rd_valid,
    input logic              int_n,
    input fbytes_t           flag_q,
    input fbytes_t           mask_q,
    input logic              rdy_q,
    input logic              dnr_q
);
    logic rd_b3;
    assign rd_b3 = rd_en && (host_addr == ADDR_W'(FLAG_BASE));

    p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_b3 |=> ((flag_q[0] & $past(flag_q[0])) == $past(flag_q[0])));

    p_evwins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b3 |=> ((flag_q[0] & $past({tx_los_ev, rx_los_ev})) == $past({tx_los_ev, rx_los_ev})));

    p_maskhold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));

    p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == all_valid() && !rdy_q) |-> int_n);

    p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dnr_q) |-> !int_n);

    p_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_novalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

bind flag_irq_ctrl flag_irq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_los_ev (rx_los_ev),
    .tx_los_ev (tx_los_ev),
    .host_addr (host_addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .rd_valid  (rd_valid),
    .int_n     (int_n),
    .flag_q    (flag_q),
    .mask_q    (mask_q),
    .rdy_q     (rdy_q),
    .dnr_q     (dnr_q)
);

// File: tb/tb_flag_irq_ctrl.sv
module tb_flag_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int INIT       = 16;
    localparam int MB         = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rx_los_ev = '0, tx_los_ev = '0, tx_fault_ev = '0;
    logic [7:0] mon_ev = '0;
    logic [7:0] host_addr = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rd_valid, int_n;

    int n_checks = 0, n_fail = 0, cyc = 0;

    logic [7:0] mflag [3];
    logic [7:0] mmask [3];
    logic       mrdy = 1'b0;
    logic       mdnr = 1'b1;

    flag_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rx_los_ev(rx_los_ev), .tx_los_ev(tx_los_ev),
        .tx_fault_ev(tx_fault_ev), .mon_ev(mon_ev), .host_addr(host_addr),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .rd_valid(rd_valid), .int_n(int_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic model_irq();
        logic r = mrdy;
        for (int i = 0; i < 3; i++) r |= |(mflag[i] & ~mmask[i]);
        return r;
    endfunction

    function automatic logic [7:0] vbits(input int i);
        return (i == 1) ? 8'h0F : 8'hFF;
    endfunction

    // one cycle: drive at negedge, model the edge, check at next negedge
    task automatic step(input logic [3:0] rx, input logic [3:0] tx, input logic [3:0] tf,
                        input logic [7:0] mon, input logic rd, input logic wr,
                        input logic [7:0] addr, input logic [7:0] wd, input string tag);
        logic [7:0] exp_rd = 8'h00;
        rx_los_ev = rx; tx_los_ev = tx; tx_fault_ev = tf; mon_ev = mon;
        rd_en = rd; wr_en = wr; host_addr = addr; wr_data = wd;
        if (rd) begin
            if (addr == 8'd2) begin exp_rd = {6'b0, model_irq(), mdnr}; mrdy = 1'b0; end
            for (int i = 0; i < 3; i++) begin
                if (addr == 8'(3 + i)) begin exp_rd = mflag[i]; mflag[i] = 8'h00; end
                if (addr == 8'(MB + i)) exp_rd = mmask[i];
            end
        end
        if (wr) for (int i = 0; i < 3; i++) if (addr == 8'(MB + i)) mmask[i] = wd & vbits(i);
        mflag[0] |= {tx, rx};
        mflag[1] |= {4'b0, tf};
        mflag[2] |= mon;
        @(negedge clk);
        rx_los_ev = '0; tx_los_ev = '0; tx_fault_ev = '0; mon_ev = '0;
        rd_en = 1'b0; wr_en = 1'b0;
        chk(rd_valid == rd, {tag, " R10 rd_valid"}, rd_valid, rd);
        if (rd) chk(rd_data == exp_rd, {tag, " rd_data"}, rd_data, exp_rd);
        chk(int_n == !model_irq(), {tag, " R7 int_n"}, int_n, !model_irq());
    endtask

    task automatic idle(input string tag);
        step('0, '0, '0, '0, 1'b0, 1'b0, 8'd0, 8'd0, tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step('0, '0, '0, '0, 1'b1, 1'b0, a, 8'd0, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) begin mflag[i] = 0; mmask[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(int_n == 1'b1, "R7 reset int_n", int_n, 1);
        rd(8'd2, "R8 status during init");
        rd(8'd100, "R6 mask reset byte3");
        rd(8'd101, "R6 mask reset byte4");
        rd(8'd102, "R6 mask reset byte5");
        while (int_n && cyc < INIT + 10) @(negedge clk);
        chk(cyc == INIT, "R8 dnr fall cycle", cyc, INIT);
        mdnr = 1'b0; mrdy = 1'b1;
        rd(8'd2, "R8 R9 status after init");
        chk(int_n == 1'b1, "R8 released by status read", int_n, 1);

        step(4'b0100, '0, '0, '0, 1'b0, 1'b0, 0, 0, "R1 pulse");
        idle("R1 idle"); idle("R1 idle");
        rd(8'd2, "R9 status irq bit");
        rd(8'd3, "R1 R2 read rx_los");
        rd(8'd3, "R2 cleared");

        step('0, 4'b0001, '0, '0, 1'b1, 1'b0, 8'd3, 0, "R4 event with read");
        rd(8'd3, "R4 event survived");

        step(4'b1000, 4'b0010, 4'b1010, 8'h81, 1'b0, 1'b0, 0, 0, "R3 load");
        rd(8'd4, "R3 tx_fault byte");
        rd(8'd3, "R5 byte3 untouched by byte4 read");
        rd(8'd5, "R3 R5 monitor byte");

        step('0, '0, '0, '0, 1'b0, 1'b1, 8'd102, 8'hFF, "R6 mask write");
        step('0, '0, '0, 8'h3C, 1'b0, 1'b0, 0, 0, "R7 masked event");
        rd(8'd102, "R6 mask readback");
        rd(8'd102, "R6 mask kept after read");
        step('0, '0, '0, '0, 1'b0, 1'b1, 8'd101, 8'hFF, "R6 narrow mask");
        rd(8'd101, "R6 byte4 mask upper zero");
        step('0, '0, '0, '0, 1'b0, 1'b1, 8'd102, 8'h00, "R7 unmask pending");
        rd(8'd5, "R7 masked flag latched");
        rd(8'd64, "R10 unmapped");

        for (int k = 0; k < 4000; k++) begin
            logic [7:0] a;
            int op = $urandom_range(0, 9);
            logic [3:0] rx = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'b0;
            logic [3:0] tx = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'b0;
            logic [3:0] tf = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'b0;
            logic [7:0] mn = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'b0;
            case ($urandom_range(0, 5))
                0: a = 8'd2; 1: a = 8'd3; 2: a = 8'd4; 3: a = 8'd5;
                4: a = 8'(MB + $urandom_range(0, 2));
                default: a = 8'($urandom);
            endcase
            if (op < 4)      step(rx, tx, tf, mn, 1'b1, 1'b0, a, 0, "R2 R4 random read");
            else if (op < 5) step(rx, tx, tf, mn, 1'b0, 1'b1, 8'(MB + $urandom_range(0, 2)),
                                  ($urandom_range(0, 1) == 0) ? 8'h00 : 8'($urandom), "R6 random mask");
            else             step(rx, tx, tf, mn, 1'b0, 1'b0, 0, 0, "R1 random idle");
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule